// File: doc/BRIEF.md
# FIFO Page Frame Replacement Unit

This block keeps track of which virtual pages currently occupy a fixed pool of physical page frames in a demand-paged memory system. Each request carries a virtual page number and a flag that marks the access as a store. The unit looks the page up in every frame within the same cycle. It reports a hit or a fault and names the frame that now holds the page. On a fault that displaces a resident page, it also says whether that victim had to be written back.

Empty frames are filled first, lowest index first. Once every frame is occupied, the victim is always the page that was loaded longest ago. Hits never change this order. A victim that was written since it was loaded is not overwritten at once. The unit raises a write-back request naming the victim's page and stops taking new requests. It completes the fault only after an acknowledge arrives. A clean victim is replaced in the same cycle as the request. Running hit and fault totals are available as outputs.

Top module: `fifo_frame_replacer`

## Requirements
- R1: After reset no frame holds a page, both counters read zero, `req_ready` is 1, and `rsp_valid` and `wb_req` are 0.
- R2: A request whose page is resident produces `rsp_valid`=1 on the next cycle with `rsp_hit`=1, `rsp_evict`=0, `rsp_frame` equal to the frame holding that page, and `hit_count` increased by one.
- R3: A request whose page is not resident, including the first reference to any page, is a fault: `fault_count` increases by one on the cycle after acceptance and `rsp_hit`=0.
- R4: While a frame is unused, a fault installs the page in the lowest-numbered unused frame with `rsp_evict`=0 and no write-back.
- R5: When all frames are occupied, a fault evicts the page loaded earliest (strict loading order, unaffected by hits), reports it on `rsp_victim` with `rsp_evict`=1, and installs the new page in that frame.
- R6: A store hit marks its frame modified, and a store that faults installs its page already marked modified.
- R7: If the victim is modified, the cycle after acceptance shows `wb_req`=1 with `wb_page` equal to the victim page and `req_ready`=0. These hold with no response until a cycle with `wb_ack`=1. The response (`rsp_wb`=1, `rsp_evict`=1) appears on the following cycle together with `req_ready`=1.
- R8: If the victim is unmodified, no write-back is requested: the response comes on the next cycle with `rsp_evict`=1 and `rsp_wb`=0.
- R9: Reading pages 1,2,3,4,1,2,5,1,2,3,4,5 from reset as loads gives 9 faults and 3 hits with 3 frames, and 10 faults and 2 hits with 4 frames.
- R10: A request presented while `req_ready`=0 is ignored: neither counter changes and the table is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_page | input | PAGE_W | Virtual page number of the request |
| req_store | input | 1 | 1 when the access is a store |
| req_ready | output | 1 | Unit can accept a request this cycle |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Page was resident |
| rsp_frame | output | IDX_W | Frame now holding the page |
| rsp_evict | output | 1 | A resident page was displaced |
| rsp_wb | output | 1 | Displaced page was written back |
| rsp_victim | output | PAGE_W | Page number that was displaced |
| wb_req | output | 1 | Write-back of `wb_page` requested |
| wb_page | output | PAGE_W | Page to be written back |
| wb_ack | input | 1 | Write-back finished |
| hit_count | output | CNT_W | Running hit total |
| fault_count | output | CNT_W | Running fault total |

## Verification
Properties checked on every cycle cover the handshake and the counting. Each accepted request adds exactly one to the combined counters. Nothing is counted while `req_ready` is low. Every acceptance is followed by either a response or a write-back request. A pending write-back blocks new requests and keeps its page stable until the acknowledge, and the response follows the acknowledge by one cycle. Properties cannot show which frame is chosen: free-frame allocation order, the victim order under interleaved hits, dirty tracking through store hits and store faults, and the two fault totals for the three- and four-frame runs. These are shown by the bench scenarios against a queue-based reference model.

// File: rtl/frame_pkg.sv
package frame_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_WB   = 1'b1
   } repl_state_e;
endpackage

// File: rtl/frame_table.sv
module frame_table #(
   parameter int FRAMES = 4,
   parameter int PAGE_W = 8,
   localparam int IDX_W = $clog2(FRAMES)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [PAGE_W-1:0]              wr_page,
   input  logic                           wr_dirty,
   input  logic                           mark_en,
   input  logic [IDX_W-1:0]               mark_idx,
   output logic [FRAMES-1:0]              valid_vec,
   output logic [FRAMES-1:0]              dirty_vec,
   output logic [FRAMES-1:0][PAGE_W-1:0]  tag_vec
);
   for (genvar f = 0; f < FRAMES; f++) begin : g_frame
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_vec[f] <= 1'b0;
            dirty_vec[f] <= 1'b0;
            tag_vec[f]   <= '0;
         end else if (wr_en && wr_idx == IDX_W'(f)) begin
            valid_vec[f] <= 1'b1;
            dirty_vec[f] <= wr_dirty;
            tag_vec[f]   <= wr_page;
         end else if (mark_en && mark_idx == IDX_W'(f)) begin
            dirty_vec[f] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/frame_lookup.sv
module frame_lookup #(
   parameter int FRAMES = 4,
   parameter int PAGE_W = 8,
   localparam int IDX_W = $clog2(FRAMES)
) (
   input  logic [FRAMES-1:0]              valid_vec,
   input  logic [FRAMES-1:0][PAGE_W-1:0]  tag_vec,
   input  logic [PAGE_W-1:0]              page,
   output logic                           hit,
   output logic [IDX_W-1:0]               hit_idx,
   output logic                           any_free,
   output logic [IDX_W-1:0]               free_idx
);
   logic [FRAMES-1:0] match;

   for (genvar f = 0; f < FRAMES; f++) begin : g_cmp
      assign match[f] = valid_vec[f] && (tag_vec[f] == page);
   end

   always_comb begin
      hit      = |match;
      hit_idx  = '0;
      any_free = 1'b0;
      free_idx = '0;
      for (int i = FRAMES - 1; i >= 0; i--) begin
         if (match[i]) hit_idx = IDX_W'(i);
         if (!valid_vec[i]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/fifo_age_ptr.sv
module fifo_age_ptr #(
   parameter int FRAMES = 4,
   localparam int IDX_W = $clog2(FRAMES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [IDX_W-1:0] oldest
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);
   localparam bit POW2 = ((FRAMES & (FRAMES - 1)) == 0);

   if (POW2) begin : g_wrap_free
      always_ff @(posedge clk) begin
         if (!rst_n)       oldest <= '0;
         else if (advance) oldest <= oldest + 1'b1;
      end
   end else begin : g_wrap_cmp
      always_ff @(posedge clk) begin
         if (!rst_n)       oldest <= '0;
         else if (advance) oldest <= (oldest == LAST) ? '0 : oldest + 1'b1;
      end
   end
endmodule

// File: rtl/fifo_frame_replacer.sv
module fifo_frame_replacer #(
   parameter int FRAMES = 4,
   parameter int PAGE_W = 8,
   parameter int CNT_W  = 16,
   localparam int IDX_W = $clog2(FRAMES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [PAGE_W-1:0] req_page,
   input  logic              req_store,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [IDX_W-1:0]  rsp_frame,
   output logic              rsp_evict,
   output logic              rsp_wb,
   output logic [PAGE_W-1:0] rsp_victim,
   output logic              wb_req,
   output logic [PAGE_W-1:0] wb_page,
   input  logic              wb_ack,
   output logic [CNT_W-1:0]  hit_count,
   output logic [CNT_W-1:0]  fault_count
);
   import frame_pkg::*;

   if (FRAMES < 2)  begin : g_bad_frames $error("FRAMES must be at least 2"); end
   if (PAGE_W < 1)  begin : g_bad_page   $error("PAGE_W must be positive");  end
   if (CNT_W < 4)   begin : g_bad_cnt    $error("CNT_W must be at least 4"); end

   repl_state_e              state;
   logic [FRAMES-1:0]        valid_vec, dirty_vec;
   logic [FRAMES-1:0][PAGE_W-1:0] tag_vec;
   logic                     hit, any_free;
   logic [IDX_W-1:0]         hit_idx, free_idx, oldest;
   logic                     accept;
   logic                     wr_en, wr_dirty, mark_en, advance;
   logic [IDX_W-1:0]         wr_idx;
   logic [PAGE_W-1:0]        wr_page;
   logic [PAGE_W-1:0]        pend_page;
   logic                     pend_store;
   logic                     wb_done;

   assign req_ready = (state == ST_IDLE);
   assign wb_req    = (state == ST_WB);
   assign accept    = req_valid && req_ready;
   assign wb_done   = wb_req && wb_ack;

   frame_table #(.FRAMES(FRAMES), .PAGE_W(PAGE_W)) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_page(wr_page), .wr_dirty(wr_dirty),
      .mark_en(mark_en), .mark_idx(hit_idx),
      .valid_vec(valid_vec), .dirty_vec(dirty_vec), .tag_vec(tag_vec)
   );

   frame_lookup #(.FRAMES(FRAMES), .PAGE_W(PAGE_W)) u_lookup (
      .valid_vec(valid_vec), .tag_vec(tag_vec), .page(req_page),
      .hit(hit), .hit_idx(hit_idx), .any_free(any_free), .free_idx(free_idx)
   );

   fifo_age_ptr #(.FRAMES(FRAMES)) u_age (
      .clk(clk), .rst_n(rst_n), .advance(advance), .oldest(oldest)
   );

   // Table update decisions for the current cycle.
   always_comb begin
      wr_en    = 1'b0;
      wr_idx   = oldest;
      wr_page  = req_page;
      wr_dirty = req_store;
      mark_en  = 1'b0;
      advance  = 1'b0;
      if (wb_done) begin
         wr_en    = 1'b1;
         wr_page  = pend_page;
         wr_dirty = pend_store;
         advance  = 1'b1;
      end else if (accept) begin
         if (hit) begin
            mark_en = req_store;
         end else if (any_free) begin
            wr_en  = 1'b1;
            wr_idx = free_idx;
         end else if (!dirty_vec[oldest]) begin
            wr_en   = 1'b1;
            advance = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         pend_page   <= '0;
         pend_store  <= 1'b0;
         wb_page     <= '0;
         rsp_valid   <= 1'b0;
         rsp_hit     <= 1'b0;
         rsp_frame   <= '0;
         rsp_evict   <= 1'b0;
         rsp_wb      <= 1'b0;
         rsp_victim  <= '0;
         hit_count   <= '0;
         fault_count <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (wb_done) begin
            state      <= ST_IDLE;
            rsp_valid  <= 1'b1;
            rsp_hit    <= 1'b0;
            rsp_frame  <= oldest;
            rsp_evict  <= 1'b1;
            rsp_wb     <= 1'b1;
            rsp_victim <= wb_page;
         end else if (accept) begin
            rsp_hit    <= hit;
            rsp_evict  <= 1'b0;
            rsp_wb     <= 1'b0;
            rsp_victim <= '0;
            if (hit) begin
               hit_count <= hit_count + 1'b1;
               rsp_valid <= 1'b1;
               rsp_frame <= hit_idx;
            end else begin
               fault_count <= fault_count + 1'b1;
               if (any_free) begin
                  rsp_valid <= 1'b1;
                  rsp_frame <= free_idx;
               end else if (dirty_vec[oldest]) begin
                  state      <= ST_WB;
                  pend_page  <= req_page;
                  pend_store <= req_store;
                  wb_page    <= tag_vec[oldest];
               end else begin
                  rsp_valid  <= 1'b1;
                  rsp_frame  <= oldest;
                  rsp_evict  <= 1'b1;
                  rsp_victim <= tag_vec[oldest];
               end
            end
         end
      end
   end
endmodule

// File: rtl/frame_replacer_checker.sv
module frame_replacer_checker #(
   parameter int PAGE_W = 8,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic              rsp_evict,
   input logic              rsp_wb,
   input logic              wb_req,
   input logic              wb_ack,
   input logic [PAGE_W-1:0] wb_page,
   input logic [CNT_W-1:0]  hit_count,
   input logic [CNT_W-1:0]  fault_count
);
   logic             took;
   logic [CNT_W:0]   total;
   assign took  = req_valid && req_ready && rst_n;
   assign total = {1'b0, hit_count} + {1'b0, fault_count};

   // R3 / R2: every accepted request is counted exactly once
   a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      took |=> (total == $past(total) + 1'b1));

   // R10: nothing is counted while the unit is stalled
   a_r10_stall_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> ($stable(hit_count) && $stable(fault_count)));

   // R2: acceptance is answered by a response or a write-back request
   a_r2_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
      took |=> (rsp_valid || wb_req));

   // R7: a pending write-back blocks requests
   a_r7_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> !req_ready);

   // R7: write-back request holds with a stable page until acknowledged
   a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_req && !wb_ack) |=> (wb_req && $stable(wb_page) && !rsp_valid));

   // R7: response with write-back flag follows the acknowledge
   a_r7_resp_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_req && wb_ack) |=> (rsp_valid && rsp_wb && rsp_evict && req_ready));

   // R8: write-back flag only accompanies an eviction; hits never evict
   a_r8_flag_consistency: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (!(rsp_wb && !rsp_evict) && !(rsp_hit && rsp_evict)));
endmodule

bind fifo_frame_replacer frame_replacer_checker #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_evict(rsp_evict), .rsp_wb(rsp_wb),
   .wb_req(wb_req), .wb_ack(wb_ack), .wb_page(wb_page),
   .hit_count(hit_count), .fault_count(fault_count)
);

// File: tb/tb_fifo_frame_replacer.sv
module tb_fifo_frame_replacer;
   localparam int CLK_PERIOD = 10;
   localparam int NF     = 4;
   localparam int PAGE_W = 8;
   localparam int CNT_W  = 16;
   localparam int IDX_W  = $clog2(NF);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [PAGE_W-1:0] req_page = '0;
   logic req_store = 1'b0;
   logic wb_ack = 1'b0;
   logic phase_b = 1'b0;

   logic req_ready, rsp_valid, rsp_hit, rsp_evict, rsp_wb, wb_req;
   logic [IDX_W-1:0] rsp_frame;
   logic [PAGE_W-1:0] rsp_victim, wb_page;
   logic [CNT_W-1:0] hit_count, fault_count;

   logic f3_ready, f3_rv, f3_hit, f3_ev, f3_wb, f3_wbreq;
   logic [1:0] f3_frame;
   logic [PAGE_W-1:0] f3_victim, f3_wbpage;
   logic [CNT_W-1:0] f3_hits, f3_faults;

   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fifo_frame_replacer #(.FRAMES(NF), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_page(req_page),
      .req_store(req_store), .req_ready(req_ready), .rsp_valid(rsp_valid),
      .rsp_hit(rsp_hit), .rsp_frame(rsp_frame), .rsp_evict(rsp_evict),
      .rsp_wb(rsp_wb), .rsp_victim(rsp_victim), .wb_req(wb_req),
      .wb_page(wb_page), .wb_ack(wb_ack), .hit_count(hit_count),
      .fault_count(fault_count));

   fifo_frame_replacer #(.FRAMES(3), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) dut_f3 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid && phase_b),
      .req_page(req_page), .req_store(1'b0), .req_ready(f3_ready),
      .rsp_valid(f3_rv), .rsp_hit(f3_hit), .rsp_frame(f3_frame),
      .rsp_evict(f3_ev), .rsp_wb(f3_wb), .rsp_victim(f3_victim),
      .wb_req(f3_wbreq), .wb_page(f3_wbpage), .wb_ack(1'b0),
      .hit_count(f3_hits), .fault_count(f3_faults));

   // Behavioural reference: arrays plus a queue of frames in loading order
   int m_valid[NF];
   int m_page[NF];
   int m_dirty[NF];
   int order[$];
   int m_hits, m_faults;

   task automatic check_eq(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < NF; i++) begin
         m_valid[i] = 0; m_page[i] = 0; m_dirty[i] = 0;
      end
      order.delete();
      m_hits = 0; m_faults = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; req_valid = 1'b0; wb_ack = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      @(negedge clk);
      check_eq("R1", "req_ready", int'(req_ready), 1);
      check_eq("R1", "rsp_valid", int'(rsp_valid), 0);
      check_eq("R1", "wb_req", int'(wb_req), 0);
      check_eq("R1", "hit_count", int'(hit_count), 0);
      check_eq("R1", "fault_count", int'(fault_count), 0);
   endtask

   // One access; ack_delay = idle cycles before wb_ack when a write-back occurs
   task automatic access(int page, bit store, int ack_delay);
      int  fr, victim, ev, wb, hit;
      hit = 0; fr = -1; ev = 0; wb = 0; victim = 0;
      for (int i = 0; i < NF; i++)
         if (m_valid[i] != 0 && m_page[i] == page) begin hit = 1; fr = i; end
      if (hit != 0) begin
         m_hits++;
         if (store) m_dirty[fr] = 1;
      end else begin
         m_faults++;
         for (int i = NF - 1; i >= 0; i--) if (m_valid[i] == 0) fr = i;
         if (fr < 0) begin
            fr = order.pop_front();
            ev = 1; victim = m_page[fr]; wb = m_dirty[fr];
         end
         order.push_back(fr);
         m_valid[fr] = 1; m_page[fr] = page; m_dirty[fr] = int'(store);
      end

      @(negedge clk);
      check_eq("R10", "req_ready before request", int'(req_ready), 1);
      req_valid = 1'b1; req_page = PAGE_W'(page); req_store = store;
      @(negedge clk);
      req_valid = 1'b0;
      check_eq("R3", "fault_count", int'(fault_count), m_faults);
      check_eq("R2", "hit_count", int'(hit_count), m_hits);
      if (wb != 0) begin
         check_eq("R7", "wb_req", int'(wb_req), 1);
         check_eq("R7", "wb_page", int'(wb_page), victim);
         check_eq("R7", "req_ready low", int'(req_ready), 0);
         check_eq("R7", "rsp held", int'(rsp_valid), 0);
         for (int k = 0; k < ack_delay; k++) begin
            if (k == 0 && ack_delay >= 2) begin
               req_valid = 1'b1; req_page = PAGE_W'(page + 100); req_store = 1'b1;
            end
            @(negedge clk);
            req_valid = 1'b0;
            check_eq("R7", "wb_req held", int'(wb_req), 1);
            check_eq("R7", "rsp held", int'(rsp_valid), 0);
            check_eq("R10", "hits while stalled", int'(hit_count), m_hits);
            check_eq("R10", "faults while stalled", int'(fault_count), m_faults);
         end
         wb_ack = 1'b1;
         @(negedge clk);
         wb_ack = 1'b0;
         check_eq("R7", "wb_req dropped", int'(wb_req), 0);
         check_eq("R7", "req_ready back", int'(req_ready), 1);
      end else if (ev != 0) begin
         check_eq("R8", "no wb_req", int'(wb_req), 0);
      end
      check_eq(hit ? "R2" : "R3", "rsp_valid", int'(rsp_valid), 1);
      check_eq(hit ? "R2" : "R3", "rsp_hit", int'(rsp_hit), hit);
      check_eq(ev ? "R5" : "R4", "rsp_frame", int'(rsp_frame), fr);
      check_eq(ev ? "R5" : "R4", "rsp_evict", int'(rsp_evict), ev);
      check_eq(wb ? "R7" : "R8", "rsp_wb", int'(rsp_wb), wb);
      if (ev != 0) check_eq("R5", "rsp_victim", int'(rsp_victim), victim);
   endtask

   initial begin
      int seq[12] = '{1, 2, 3, 4, 1, 2, 5, 1, 2, 3, 4, 5};
      do_reset();
      // R9: loading-order anomaly run on both frame counts at once
      phase_b = 1'b1;
      foreach (seq[i]) access(seq[i], 1'b0, 0);
      phase_b = 1'b0;
      check_eq("R9", "4-frame faults", int'(fault_count), 10);
      check_eq("R9", "4-frame hits", int'(hit_count), 2);
      check_eq("R9", "3-frame faults", int'(f3_faults), 9);
      check_eq("R9", "3-frame hits", int'(f3_hits), 3);

      do_reset();
      // R4, R6: fill free frames in order, some by stores
      access(10, 1'b1, 0);
      access(11, 1'b0, 0);
      access(12, 1'b1, 0);
      access(13, 1'b0, 0);
      // R2, R6: store hit dirties frame 1; hits leave order alone (R5)
      access(11, 1'b1, 0);
      access(10, 1'b0, 0);
      // R5, R7: dirty victims with varied acknowledge delays, R10 junk
      access(14, 1'b0, 0);
      access(15, 1'b1, 3);
      access(16, 1'b0, 1);
      // R8: clean victims
      access(17, 1'b0, 0);
      access(14, 1'b0, 0);
      access(18, 1'b0, 0);
      // R6: page loaded by a store fault is dirty when evicted
      access(15, 1'b0, 0);
      access(19, 1'b0, 2);
      access(20, 1'b1, 0);
      access(21, 1'b0, 0);
      access(22, 1'b0, 0);
      access(23, 1'b0, 0);
      access(24, 1'b0, 4);
      access(23, 1'b1, 0);
      check_eq("R3", "final faults", int'(fault_count), m_faults);
      check_eq("R2", "final hits", int'(hit_count), m_hits);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule